// File: doc/BRIEF.md
# Display RAM Write Address Generator

This block keeps the write pointers of a display memory that is organised as 102 columns by a set of eight-bit-high banks. A host loads a column pointer (X), a bank pointer (Y), two wrap limits and two mode bits through single-cycle command strobes that share one value bus. Every data write strobe then produces a physical column, a bank number, a bit-enable mask and a write enable for the RAM. After the write, the pointers advance automatically.

Two advance orders exist. In horizontal order, X steps first and carries into Y. In vertical order, Y steps first and carries into X. Each pointer returns to zero once it has reached its limit. A mirror bit reverses the column order at the RAM side, so logical column 0 lands on the rightmost physical column. Bank 8 is three pixels tall and bank 10 is one pixel tall, so writes to those banks carry a narrowed mask. Bank 10 can be reached only by loading Y directly. The automatic advance never reaches it.

Top module: `lcd_wr_addr_gen`

## Requirements
- R1: After reset X = 0, Y = 0, X limit = 101, Y limit = 8, MX = 0 and V = 0.
- R2: A set_x strobe loads cmd_val (0..101) into X. A value above 101 is ignored and the old X is kept.
- R3: A set_y strobe loads cmd_val[3:0] into Y when it is 0..8 or 10. The values 9 and 11..15 are ignored and the old Y is kept.
- R4: A set_xmax strobe loads cmd_val into the X limit if it is 101 or less. A set_ymax strobe loads cmd_val[3:0] into the Y limit if it is 8 or less. Larger values are ignored.
- R5: A set_mode strobe loads MX from cmd_val[1] and V from cmd_val[0].
- R6: ram_we equals wr_stb while no command strobe is high. While any command strobe is high, ram_we is 0 and the pointers do not advance.
- R7: ram_col equals X when MX = 0 and 101 − X when MX = 1. ram_bank equals Y.
- R8: ram_mask is 8'h07 for bank 8 (bits 0 to 2), 8'h01 for bank 10 (bit 0) and 8'hFF for every other bank.
- R9: With V = 0, a write advances X. Only when X wraps does Y advance.
- R10: With V = 1, a write advances Y. Only when Y wraps does X advance.
- R11: A pointer that is advanced while it is at or above its limit becomes 0. Otherwise it increases by one. Bank 10 therefore always wraps to 0.
- R12: X, Y, the limits and the mode bits change only on a write or on their own set strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_x | input | 1 | Load X from cmd_val |
| set_y | input | 1 | Load Y from cmd_val[3:0] |
| set_xmax | input | 1 | Load X limit from cmd_val |
| set_ymax | input | 1 | Load Y limit from cmd_val[3:0] |
| set_mode | input | 1 | Load MX (bit 1) and V (bit 0) from cmd_val |
| cmd_val | input | 7 | Command value |
| wr_stb | input | 1 | Data write strobe |
| ram_col | output | 7 | Physical RAM column |
| ram_bank | output | 4 | RAM bank |
| ram_mask | output | 8 | Bit enables within the bank byte |
| ram_we | output | 1 | RAM write enable |

## Verification
The pointers are always visible on ram_col and ram_bank, not only during writes. A wrong increment, a wrong wrap or a corrupted limit therefore shows up on the cycle after the write that caused it, as a column or bank that differs from the reference model. A wrong limit or mode register may stay hidden until the pointer reaches that limit, or until a write arrives in that mode. For this reason the stimulus walks the pointers through complete wrap cycles in both orders, with small limits. An ignored-value fault shows up right after the offending set strobe, because the pointer it wrongly changed is on the ports.

// File: rtl/lcd_wr_addr_gen.sv
module lcd_wr_addr_gen #(
  parameter int XW    = 7,
  parameter int YW    = 4,
  parameter int XLAST = 101,
  parameter int YLAST = 8,
  parameter int YICON = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_x,
  input  logic          set_y,
  input  logic          set_xmax,
  input  logic          set_ymax,
  input  logic          set_mode,
  input  logic [XW-1:0] cmd_val,
  input  logic          wr_stb,
  output logic [XW-1:0] ram_col,
  output logic [YW-1:0] ram_bank,
  output logic [7:0]    ram_mask,
  output logic          ram_we
);
  localparam logic [XW-1:0] XTOP = XW'(XLAST);
  localparam logic [YW-1:0] YTOP = YW'(YLAST);
  localparam logic [YW-1:0] YIC  = YW'(YICON);

  logic [XW-1:0] x_q, xmax_q, x_nxt;
  logic [YW-1:0] y_q, ymax_q, y_nxt;
  logic          mx_q, v_q;
  logic          any_cmd, wrap_x, wrap_y, x_ok, y_ok, ylim_ok;
  logic [YW-1:0] yv;

  assign any_cmd = set_x | set_y | set_xmax | set_ymax | set_mode;
  assign ram_we  = wr_stb & ~any_cmd;
  assign yv      = cmd_val[YW-1:0];
  assign x_ok    = cmd_val <= XTOP;
  assign y_ok    = (yv <= YTOP) || (yv == YIC);
  assign ylim_ok = yv <= YTOP;

  assign wrap_x = x_q >= xmax_q;
  assign wrap_y = y_q >= ymax_q;
  assign x_nxt  = wrap_x ? '0 : x_q + 1'b1;
  assign y_nxt  = wrap_y ? '0 : y_q + 1'b1;

  assign ram_col  = mx_q ? XTOP - x_q : x_q;
  assign ram_bank = y_q;
  assign ram_mask = (y_q == YTOP) ? 8'h07 : (y_q == YIC) ? 8'h01 : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      xmax_q <= XTOP;
      ymax_q <= YTOP;
      mx_q   <= 1'b0;
      v_q    <= 1'b0;
    end else if (any_cmd) begin
      if (set_x && x_ok)        x_q    <= cmd_val;
      if (set_y && y_ok)        y_q    <= yv;
      if (set_xmax && x_ok)     xmax_q <= cmd_val;
      if (set_ymax && ylim_ok)  ymax_q <= yv;
      if (set_mode) begin
        mx_q <= cmd_val[1];
        v_q  <= cmd_val[0];
      end
    end else if (wr_stb) begin
      if (!v_q) begin
        x_q <= x_nxt;
        if (wrap_x) y_q <= y_nxt;
      end else begin
        y_q <= y_nxt;
        if (wrap_y) x_q <= x_nxt;
      end
    end
  end
endmodule

module lcd_wr_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_y,
  input logic       set_x,
  input logic [6:0] cmd_val,
  input logic       ram_we,
  input logic [6:0] ram_col,
  input logic [3:0] ram_bank,
  input logic [7:0] ram_mask,
  input logic [6:0] x_q,
  input logic [6:0] xmax_q,
  input logic [3:0] ymax_q,
  input logic       v_q
);
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ram_col <= 7'd101); // R7
  AST_BANK_VALID: assert property (@(posedge clk) disable iff (!rst_n) (ram_bank <= 4'd8) || (ram_bank == 4'd10)); // R3
  AST_MASK_B8: assert property (@(posedge clk) disable iff (!rst_n) (ram_bank == 4'd8) |-> ram_mask == 8'h07); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!ram_we && !set_x && !set_y) |=> $stable(x_q) && $stable(ram_bank)); // R12
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ram_we && !v_q && x_q < xmax_q) |=> x_q == $past(x_q) + 7'd1); // R9
  AST_V_HOLDX: assert property (@(posedge clk) disable iff (!rst_n) (ram_we && v_q && ram_bank < ymax_q) |=> $stable(x_q)); // R10
  AST_Y_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (set_y && cmd_val[3:0] == 4'd9) |=> $stable(ram_bank)); // R3
endmodule

bind lcd_wr_addr_gen lcd_wr_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_y(set_y), .set_x(set_x), .cmd_val(cmd_val),
  .ram_we(ram_we), .ram_col(ram_col), .ram_bank(ram_bank), .ram_mask(ram_mask),
  .x_q(x_q), .xmax_q(xmax_q), .ymax_q(ymax_q), .v_q(v_q)
);

// File: tb/test_lcd_wr_addr_gen.sv
module test_lcd_wr_addr_gen;
  logic clk = 0, rst_n = 0;
  logic set_x = 0, set_y = 0, set_xmax = 0, set_ymax = 0, set_mode = 0, wr_stb = 0;
  logic [6:0] cmd_val = 0;
  logic [6:0] ram_col;
  logic [3:0] ram_bank;
  logic [7:0] ram_mask;
  logic ram_we;
  int n_cmp = 0, n_bad = 0;
  int mx, vv, rx, ry, rxm, rym;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_wr_addr_gen i_lcd_wr_addr_gen (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx = 0; ry = 0; rxm = 101; rym = 8; mx = 0; vv = 0;
    end else if (set_x | set_y | set_xmax | set_ymax | set_mode) begin
      if (set_x && cmd_val <= 101) rx = cmd_val;
      if (set_y && (cmd_val[3:0] <= 8 || cmd_val[3:0] == 10)) ry = cmd_val[3:0];
      if (set_xmax && cmd_val <= 101) rxm = cmd_val;
      if (set_ymax && cmd_val[3:0] <= 8) rym = cmd_val[3:0];
      if (set_mode) begin mx = cmd_val[1]; vv = cmd_val[0]; end
    end else if (wr_stb) begin
      if (vv == 0) begin
        if (rx >= rxm) begin rx = 0; ry = (ry >= rym) ? 0 : ry + 1; end
        else rx = rx + 1;
      end else begin
        if (ry >= rym) begin ry = 0; rx = (rx >= rxm) ? 0 : rx + 1; end
        else ry = ry + 1;
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("R7 R9 R10 R11 col", ram_col, (mx != 0) ? 101 - rx : rx);
    cmp("R3 R9 R10 R11 bank", ram_bank, ry);
    cmp("R8 mask", ram_mask, (ry == 8) ? 7 : (ry == 10) ? 1 : 255);
    cmp("R6 we", ram_we, wr_stb & ~(set_x | set_y | set_xmax | set_ymax | set_mode));
  end

  task automatic idle();
    @(posedge clk); #1;
    {set_x, set_y, set_xmax, set_ymax, set_mode, wr_stb} = 0;
  endtask
  task automatic cmd(int which, int val);
    @(posedge clk); #1;
    {set_x, set_y, set_xmax, set_ymax, set_mode, wr_stb} = 0;
    cmd_val = val[6:0];
    case (which)
      0: set_x = 1; 1: set_y = 1; 2: set_xmax = 1; 3: set_ymax = 1; default: set_mode = 1;
    endcase
  endtask
  task automatic wr(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      {set_x, set_y, set_xmax, set_ymax, set_mode} = 0;
      wr_stb = 1;
    end
  endtask
  task automatic chk_pos(string tag, int col, int bank);
    @(negedge clk);
    cmp(tag, ram_col, col);
    cmp(tag, ram_bank, bank);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    chk_pos("R1 reset", 0, 0);
    cmp("R1 mask", ram_mask, 255);
    // R1 limits: 101 writes leave X at 101, one more wraps into bank 1
    wr(101); idle(); chk_pos("R1 xlimit", 101, 0);
    wr(1); idle(); chk_pos("R11 R9 wrap", 0, 1);
    cmd(0, 55); idle(); chk_pos("R2 setx", 55, 1);
    cmd(0, 102); idle(); chk_pos("R2 ignore", 55, 1);
    cmd(1, 9); idle(); chk_pos("R3 ignore9", 55, 1);
    cmd(1, 12); idle(); chk_pos("R3 ignore12", 55, 1);
    cmd(1, 10); idle(); chk_pos("R3 bank10", 55, 10);
    cmp("R8 bank10 mask", ram_mask, 1);
    cmd(1, 8); idle(); cmp("R8 bank8 mask", ram_mask, 7);
    cmd(4, 2); idle(); chk_pos("R5 R7 mirror", 46, 8);
    cmd(4, 0);
    cmd(2, 3); cmd(3, 2); cmd(2, 120); cmd(3, 9); // R4 last two ignored
    cmd(0, 0); cmd(1, 0);
    wr(4); idle(); chk_pos("R4 R9 horiz", 0, 1);
    wr(8); idle(); chk_pos("R11 R9 ywrap", 0, 0);
    cmd(4, 1); wr(3); idle(); chk_pos("R10 vert", 1, 0);
    wr(9); idle(); chk_pos("R10 R11 xwrap", 0, 0);
    cmd(1, 10); wr(1); idle(); chk_pos("R11 bank10 wrap", 1, 0);
    @(posedge clk); #1; set_x = 1; cmd_val = 2; wr_stb = 1; idle();
    chk_pos("R6 cmd beats write", 2, 0);
    repeat (5) idle(); chk_pos("R12 hold", 2, 0);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      {set_x, set_y, set_xmax, set_ymax, set_mode, wr_stb} = 0;
      cmd_val = 7'($urandom);
      case ($urandom % 12)
        0: set_x = 1; 1: set_y = 1; 2: set_xmax = 1; 3: begin set_ymax = 1; wr_stb = 1; end
        4: set_mode = 1; 5: ; default: wr_stb = 1;
      endcase
      if ((cmd_val % 3) == 0 && set_xmax) cmd_val = 7'($urandom % 8);
    end
    idle(); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule